// File: doc/BRIEF.md
# Multi-level FSK symbol slicer

This block turns a stream of signed, already filtered frequency-discriminator samples into symbol decisions. It sits after the post-demodulation filter and before clock recovery. Each sample arrives with a valid strobe, and one clock later the block presents a 2-bit symbol code with its own strobe.

Three modes are supported: binary, ternary and quaternary. In binary mode the decision threshold is either fixed at zero or taken from a running estimate of the signal centre. That estimate is the midpoint between a peak tracker and a valley tracker, so a constant carrier offset between transmitter and receiver drops out of the decision. The same estimate is offered on a readback port for an outer frequency-correction loop. The ternary and quaternary modes compare against thresholds at plus and minus a single programmable 7-bit magnitude. The quaternary mode also compares against zero.

Top module: `fsk_slicer`

## Requirements
- R1: `out_valid` is high exactly one clock after each clock in which `in_valid` is high, and low otherwise. `out_sym` changes only in the cycle after an accepted sample.
- R2: With `mode`=00 and `track_en`=0, the output is `out_sym`=2'b01 when the sample is at or above zero and 2'b00 when it is below zero.
- R3: With `mode`=00 and `track_en`=1, the sample is compared against the value `freq_est` held before that sample. `out_sym` is 2'b01 when the sample is at or above that value and 2'b00 otherwise.
- R4: On every accepted sample, in any mode, the peak tracker is set to the sample if the sample exceeds it. Otherwise it moves down by (peak−valley)>>4. The valley tracker is set to the sample if the sample is below it. Otherwise it moves up by (peak−valley)>>4. Both steps use the values held before the sample.
- R5: `freq_est` equals floor((peak+valley)/2) and does not change in cycles without an accepted sample.
- R6: With `mode`=10 (quaternary), the code is 00 (−3) for s < −T, 01 (−1) for −T ≤ s < 0, 10 (+1) for 0 ≤ s < T, and 11 (+3) for s ≥ T.
- R7: With `mode`=01 (ternary), the code is 00 (−1) for s < −T, 10 (+1) for s > T, and 01 (0) otherwise. Code 11 never appears.
- R8: T is the 7-bit unsigned `thresh_mag`, shared by the ternary and quaternary modes. `mode`=11 behaves as binary.
- R9: A synchronous reset clears both trackers, so `freq_est` reads 0. It also clears `out_valid` and `out_sym`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SW | Signed filtered discriminator sample |
| mode | input | 2 | 00 binary, 01 ternary, 10 quaternary, 11 binary |
| track_en | input | 1 | Binary mode: 1 selects the tracking threshold, 0 selects zero |
| thresh_mag | input | 7 | Unsigned multi-level threshold magnitude T |
| out_valid | output | 1 | Symbol strobe |
| out_sym | output | 2 | Symbol code |
| freq_est | output | SW | Signed centre/offset estimate for readback |

## Verification
Quaternary and ternary decisions are driven with samples at exactly −T−1, −T, −1, 0, T−1, T and T+1. This separates strict from non-strict comparisons, and T is taken at 0 and at 127. Binary mode is fed a two-level signal riding on a large constant offset. With the zero threshold the decisions stick at one value. With tracking on they follow the data once the peak and valley trackers settle, which shows the offset correction at work. Long random runs mix modes, gaps in the strobe and full-scale samples, checked against a bench model of the trackers. This exposes errors in the decay step and the midpoint rounding, and any tracker update taken in idle cycles.

// File: rtl/fsk_slicer.sv
module fsk_slicer #(
  parameter int SW    = 12,
  parameter int DECAY = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  input  logic [1:0]           mode,
  input  logic                 track_en,
  input  logic [6:0]           thresh_mag,
  output logic                 out_valid,
  output logic [1:0]           out_sym,
  output logic signed [SW-1:0] freq_est
);
  localparam logic [1:0] M_TERN = 2'b01;
  localparam logic [1:0] M_QUAD = 2'b10;

  logic signed [SW-1:0] peak, valley;
  logic signed [SW:0]   span, step, mid_sum;
  logic signed [SW-1:0] t_pos, t_neg, bin_thr;
  logic [1:0]           sym_d;

  assign span    = peak - valley;
  assign step    = span >>> DECAY;
  assign mid_sum = peak + valley;
  assign freq_est = SW'(mid_sum >>> 1);

  assign t_pos   = $signed({{(SW-7){1'b0}}, thresh_mag});
  assign t_neg   = -t_pos;
  assign bin_thr = track_en ? freq_est : '0;

  always_comb begin
    case (mode)
      M_QUAD: begin
        if (in_sample < t_neg)      sym_d = 2'b00;
        else if (in_sample < 0)     sym_d = 2'b01;
        else if (in_sample < t_pos) sym_d = 2'b10;
        else                        sym_d = 2'b11;
      end
      M_TERN: begin
        if (in_sample < t_neg)      sym_d = 2'b00;
        else if (in_sample > t_pos) sym_d = 2'b10;
        else                        sym_d = 2'b01;
      end
      default: sym_d = {1'b0, in_sample >= bin_thr};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peak      <= '0;
      valley    <= '0;
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sym <= sym_d;
        peak    <= (in_sample > peak)   ? in_sample : SW'(peak - step);
        valley  <= (in_sample < valley) ? in_sample : SW'(valley + step);
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_sym));
  // R4
  track_order_chk: assert property (@(posedge clk) disable iff (rst)
    peak >= valley);
  // R5
  est_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(freq_est));
  // R7
  tern_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == M_TERN) |=> out_sym != 2'b11);
  // R2
  bin_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'b00 || mode == 2'b11)) |=> !out_sym[1]);
  // R6
  quad_top_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == M_QUAD && in_sample >= t_pos) |=> out_sym == 2'b11);
endmodule

// File: tb/fsk_slicer_bench.sv
module fsk_slicer_bench;
  localparam int SW = 12;
  logic clk = 0, rst = 1, in_valid = 0, track_en = 0;
  logic signed [SW-1:0] in_sample = '0;
  logic [1:0] mode = 0;
  logic [6:0] thresh_mag = 0;
  logic out_valid;
  logic [1:0] out_sym;
  logic signed [SW-1:0] freq_est;
  int tests = 0, fails = 0, cyc = 0;
  int m_pk = 0, m_vl = 0;
  logic [1:0] m_sym = 0;

  always #5 clk = ~clk;

  fsk_slicer #(.SW(SW)) u_fsk_slicer (.clk, .rst, .in_valid, .in_sample, .mode,
    .track_en, .thresh_mag, .out_valid, .out_sym, .freq_est);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int est(int p, int v);
    return (p + v) >>> 1;
  endfunction

  function automatic logic [1:0] exp_sym(logic [1:0] md, logic tr, int t, int s, int e);
    int thr;
    if (md == 2'b10) return (s < -t) ? 2'b00 : (s < 0) ? 2'b01 : (s < t) ? 2'b10 : 2'b11;
    if (md == 2'b01) return (s < -t) ? 2'b00 : (s > t) ? 2'b10 : 2'b01;
    thr = tr ? e : 0;
    return {1'b0, s >= thr};
  endfunction

  task automatic check(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(logic v, int s, logic [1:0] md, logic tr, int t, string req);
    int d;
    in_valid = v; in_sample = SW'(s); mode = md; track_en = tr; thresh_mag = 7'(t);
    if (v) begin
      m_sym = exp_sym(md, tr, t, s, est(m_pk, m_vl));
      d = (m_pk - m_vl) >>> 4;
      if (s > m_pk) m_pk = s; else m_pk = m_pk - d;
      if (s < m_vl) m_vl = s; else m_vl = m_vl + d;
    end
    @(posedge clk); @(negedge clk);
    check({req, " valid"}, out_valid, v);        // R1
    check({req, " sym"}, out_sym, m_sym);
    check("R5 R4 freq_est", freq_est, est(m_pk, m_vl));
  endtask

  initial begin
    int tv[7];
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 0; in_valid = 1; in_sample = 12'sd900;
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    rst = 0;
    check("R9 reset valid", out_valid, 0);
    check("R9 reset sym", out_sym, 0);
    check("R9 reset est", freq_est, 0);
    m_pk = 0; m_vl = 0; m_sym = 0;

    foreach (tv[i]) tv[i] = 0;
    for (int k = 0; k < 3; k++) begin
      int t = (k == 0) ? 0 : (k == 1) ? 127 : 40;
      tv = '{-t-1, -t, -1, 0, t-1, t, t+1};
      for (int i = 0; i < 7; i++) step(1, tv[i], 2'b10, 0, t, "R6 quad edge");
      for (int i = 0; i < 7; i++) step(1, tv[i], 2'b01, 0, t, "R7 R8 tern edge");
    end
    step(1, 0, 2'b00, 0, 5, "R2 zero");
    step(1, -1, 2'b00, 0, 5, "R2 minus");
    step(1, -1, 2'b11, 0, 5, "R8 mode3");
    step(0, 700, 2'b10, 0, 5, "R1 idle");
    step(0, -700, 2'b01, 0, 5, "R5 idle");

    for (int i = 0; i < 200; i++) step(1, 600 + ((i % 2) ? 300 : -300), 2'b00, 1, 0, "R3 offset");
    for (int i = 0; i < 4; i++) begin
      step(1, 900, 2'b00, 1, 0, "R3 settled hi");
      check("R3 hi decision", out_sym, 1);
      step(1, 300, 2'b00, 1, 0, "R3 settled lo");
      check("R3 lo decision", out_sym, 0);
    end
    for (int i = 0; i < 4; i++) begin
      step(1, 300, 2'b00, 0, 0, "R2 offset fixed");
      check("R2 fixed decision", out_sym, 1);
    end

    for (int i = 0; i < 4000; i++) begin
      int s = int'($urandom_range(4095)) - 2048;
      if ($urandom_range(9) == 0) s = ($urandom_range(1)) ? 2047 : -2048;
      step($urandom_range(4) != 0, s, 2'($urandom_range(3)), 1'($urandom_range(1)),
           int'($urandom_range(127)), "R4 R6 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule